// File: doc/BRIEF.md
# DMA shadow region access filter

This block is the register front-end of a DMA controller that lets eight software regions share one bank of channel event, enable and interrupt registers without stepping on each other. The bank sits behind an unmasked physical window and is also mirrored into eight shadow windows, one per region. Each region owns a set of channels, described by three programmable ownership masks: a low and a high word for the 64 DMA channels and one word for the QDMA channels. An access through a region's shadow window reaches only the bits of channels that region owns. Reads return zero in unowned bit positions. Writes of any kind leave unowned bits untouched.

Software gives each region its masks through a small set of mask registers that sit outside every window. A region then uses its own window for all routine channel control. A write of 1 to the re-evaluate word of a shadow window ignores every mask and raises a one-cycle pulse that carries the region number, so the interrupt logic downstream can fire again for that region.

Top module: `dma_shadow_filter`

## Requirements
- R1: After reset every bank register and every ownership mask reads 0, `rdData` is 0 and `revalPulse` is low.
- R2: The physical window starts at byte offset 0x1000. Bits [1:0] of the address are ignored, and the word index inside a window is addr[7:2]. Register indices: 0/1 event low/high, 2/3 chained event, 4/5 enable, 6/7 secondary event, 8/9 interrupt enable, 10/11 interrupt pending, 12 QDMA event, 13 QDMA enable, 14 QDMA secondary event. The word index w = 2j + h for w < 28, where h selects high (odd index), and slot j maps to the following (register pair, access): 0 event data, 1 event set, 2 event clear, 3 chained data, 4 enable data, 5 enable set, 6 enable clear, 7 secondary data, 8 secondary clear, 9 int-enable data, 10 int-enable set, 11 int-enable clear, 12 pending data, 13 pending clear. Words 28 to 33 are QDMA event data, QDMA enable data, QDMA enable set, QDMA enable clear, QDMA secondary data and QDMA secondary clear. Through the physical window, a data write replaces the whole word and a data read returns it.
- R3: Region n's shadow window starts at 0x2000 + n*0x200 and uses the same word layout. A data read there returns the register ANDed with the region's mask: the QDMA mask for indices 12 to 14, the DMA high mask for odd indices below 12, and the DMA low mask for even indices below 12.
- R4: A data write through a shadow window changes only the owned bits and keeps every other bit.
- R5: A set word ORs in the owned 1 bits of the write data, and a clear word clears the owned 1 bits. Unowned bits are unchanged even when written as 1. Through the physical window every bit is owned. Set and clear words read as 0.
- R6: Region n's DMA low mask is at 0x340 + 8n and its DMA high mask at 0x344 + 8n. Its QDMA mask is at 0x380 + 4n. All three are read/write and unmasked.
- R7: A write with bit 0 set to word 37 (offset 0x094) of shadow window n gives `revalPulse` high for exactly the next cycle with `revalRegion` = n. No mask affects this. A write with bit 0 clear gives no pulse. The word reads as 0.
- R8: Unmapped offsets read 0 and writes to them change nothing. These include words 34 to 36 and 38 and above of every window, offset 0x094 of the physical window, the upper half (addr[8] = 1) of each region's 0x200 span, and every other address not listed above.
- R9: `rdData` carries the value for a read in the cycle after `rdEn` is sampled high, and is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 14 | Byte address within the block |
| wrEn | input | 1 | Write strobe for this cycle |
| rdEn | input | 1 | Read strobe for this cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| revalPulse | output | 1 | One-cycle re-evaluate pulse |
| revalRegion | output | 3 | Region that requested the re-evaluate |

## Verification
The bank is first filled with a distinct pattern in every word through the physical window. It is then read back through three regions: one with a mixed ownership pattern, one that owns nothing and one that owns only the DMA low word. This separates the choice of low mask, high mask and QDMA mask, and shows that a region with no ownership sees only zeros. Data, set and clear writes with all-ones data go through a partly owning region. Physical readback of the whole bank after each of these writes shows which bits moved, so a write that leaks into unowned bits is caught. Writes to every unmapped area are followed by a full readback, and re-evaluate writes go to regions with empty masks and with bit 0 both set and clear.

// File: rtl/shadow_filter_pkg.sv
package shadow_filter_pkg;
  localparam int DataW      = 32;
  localparam int NumRegs    = 15;
  localparam int RegIdxW    = 4;
  localparam int WordW      = 6;
  localparam int NumRegions = 8;
  localparam int RegionW    = $clog2(NumRegions);
  localparam int QdmaFirst  = 12;
  localparam logic [WordW-1:0] RevalWord = 6'd37;

  typedef enum logic [1:0] {KIND_DATA = 2'd0, KIND_SET = 2'd1, KIND_CLR = 2'd2} accKind_e;

  typedef struct packed {
    logic                 hit;
    logic [RegIdxW-1:0]   idx;
    accKind_e             kind;
  } wordMap_t;

  typedef struct packed {
    logic                 wr;
    logic                 rd;
    logic                 regHit;
    logic [RegIdxW-1:0]   regIdx;
    accKind_e             kind;
    logic                 shadow;
    logic [RegionW-1:0]   region;
    logic                 maskHit;
    logic [1:0]           maskSel;
    logic [RegionW-1:0]   maskRegion;
    logic                 revalHit;
  } strobe_t;

  function automatic wordMap_t mapWord(input logic [WordW-1:0] w);
    wordMap_t   m;
    logic [2:0] base;
    m    = '{hit: 1'b1, idx: '0, kind: KIND_DATA};
    base = 3'd0;
    if (w < 6'd28) begin
      case (w[5:1])
        5'd0:  begin base = 3'd0; m.kind = KIND_DATA; end
        5'd1:  begin base = 3'd0; m.kind = KIND_SET;  end
        5'd2:  begin base = 3'd0; m.kind = KIND_CLR;  end
        5'd3:  begin base = 3'd1; m.kind = KIND_DATA; end
        5'd4:  begin base = 3'd2; m.kind = KIND_DATA; end
        5'd5:  begin base = 3'd2; m.kind = KIND_SET;  end
        5'd6:  begin base = 3'd2; m.kind = KIND_CLR;  end
        5'd7:  begin base = 3'd3; m.kind = KIND_DATA; end
        5'd8:  begin base = 3'd3; m.kind = KIND_CLR;  end
        5'd9:  begin base = 3'd4; m.kind = KIND_DATA; end
        5'd10: begin base = 3'd4; m.kind = KIND_SET;  end
        5'd11: begin base = 3'd4; m.kind = KIND_CLR;  end
        5'd12: begin base = 3'd5; m.kind = KIND_DATA; end
        default: begin base = 3'd5; m.kind = KIND_CLR; end
      endcase
      m.idx = {base, w[0]};
    end else begin
      case (w)
        6'd28:   begin m.idx = 4'd12; m.kind = KIND_DATA; end
        6'd29:   begin m.idx = 4'd13; m.kind = KIND_DATA; end
        6'd30:   begin m.idx = 4'd13; m.kind = KIND_SET;  end
        6'd31:   begin m.idx = 4'd13; m.kind = KIND_CLR;  end
        6'd32:   begin m.idx = 4'd14; m.kind = KIND_DATA; end
        6'd33:   begin m.idx = 4'd14; m.kind = KIND_CLR;  end
        default: m.hit = 1'b0;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/shadow_filter_ctrl.sv
module shadow_filter_ctrl
  import shadow_filter_pkg::*;
#(
  parameter int AddrW = 14
) (
  input  logic [AddrW-1:0] addr,
  input  logic             wrEn,
  input  logic             rdEn,
  output strobe_t          stb
);
  localparam logic [AddrW-9:0]  PhysPage   = (AddrW-8)'(16);
  localparam logic [AddrW-13:0] ShadowTop  = (AddrW-12)'(2);
  localparam logic [AddrW-7:0]  MaskDmaTop = (AddrW-6)'(13);
  localparam logic [AddrW-6:0]  MaskQTop   = (AddrW-5)'(28);

  logic [WordW-1:0] word;
  logic             inWin, physWin, shadowWin, maskDmaWin, maskQWin;
  logic             unusedBits;
  wordMap_t         wm;

  assign unusedBits = ^addr[1:0];
  assign word       = addr[7:2];
  assign inWin      = (word <= RevalWord);
  assign physWin    = (addr[AddrW-1:8] == PhysPage) && inWin;
  assign shadowWin  = (addr[AddrW-1:12] == ShadowTop) && !addr[8] && inWin;
  assign maskDmaWin = (addr[AddrW-1:6] == MaskDmaTop);
  assign maskQWin   = (addr[AddrW-1:5] == MaskQTop);
  assign wm         = mapWord(word);

  always_comb begin
    stb.wr         = wrEn;
    stb.rd         = rdEn;
    stb.regHit     = (physWin || shadowWin) && wm.hit;
    stb.regIdx     = wm.idx;
    stb.kind       = wm.kind;
    stb.shadow     = shadowWin;
    stb.region     = addr[11:9];
    stb.revalHit   = shadowWin && (word == RevalWord);
    stb.maskHit    = maskDmaWin || maskQWin;
    stb.maskSel    = maskQWin ? 2'd2 : {1'b0, addr[2]};
    stb.maskRegion = maskQWin ? addr[4:2] : addr[5:3];
  end
endmodule

// File: rtl/shadow_filter_dp.sv
module shadow_filter_dp
  import shadow_filter_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  logic [DataW-1:0]   wrData,
  output logic [DataW-1:0]   rdData,
  output logic               revalPulse,
  output logic [RegionW-1:0] revalRegion
);
  logic [DataW-1:0] bank   [NumRegs];
  logic [DataW-1:0] maskLo [NumRegions];
  logic [DataW-1:0] maskHi [NumRegions];
  logic [DataW-1:0] maskQ  [NumRegions];
  logic [DataW-1:0] effMask, oldVal, ownedWr, newVal, maskRdVal, rdNext;

  always_comb begin
    if (!stb.shadow)                         effMask = '1;
    else if (stb.regIdx >= 4'(QdmaFirst))    effMask = maskQ[stb.region];
    else if (stb.regIdx[0])                  effMask = maskHi[stb.region];
    else                                     effMask = maskLo[stb.region];
  end

  assign oldVal  = bank[stb.regIdx];
  assign ownedWr = wrData & effMask;

  always_comb begin
    case (stb.kind)
      KIND_SET: newVal = oldVal | ownedWr;
      KIND_CLR: newVal = oldVal & ~ownedWr;
      default:  newVal = (oldVal & ~effMask) | ownedWr;
    endcase
  end

  always_comb begin
    case (stb.maskSel)
      2'd0:    maskRdVal = maskLo[stb.maskRegion];
      2'd1:    maskRdVal = maskHi[stb.maskRegion];
      default: maskRdVal = maskQ[stb.maskRegion];
    endcase
  end

  always_comb begin
    if (stb.regHit && stb.kind == KIND_DATA) rdNext = oldVal & effMask;
    else if (stb.maskHit)                    rdNext = maskRdVal;
    else                                     rdNext = '0;
  end

  for (genvar g = 0; g < NumRegs; g++) begin : gBank
    always_ff @(posedge clk) begin
      if (rst)                                               bank[g] <= '0;
      else if (stb.wr && stb.regHit && stb.regIdx == 4'(g))  bank[g] <= newVal;
    end
  end

  for (genvar r = 0; r < NumRegions; r++) begin : gMask
    always_ff @(posedge clk) begin
      if (rst) begin
        maskLo[r] <= '0;
        maskHi[r] <= '0;
        maskQ[r]  <= '0;
      end else if (stb.wr && stb.maskHit && stb.maskRegion == RegionW'(r)) begin
        case (stb.maskSel)
          2'd0:    maskLo[r] <= wrData;
          2'd1:    maskHi[r] <= wrData;
          default: maskQ[r]  <= wrData;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData      <= '0;
      revalPulse  <= 1'b0;
      revalRegion <= '0;
    end else begin
      rdData      <= stb.rd ? rdNext : '0;
      revalPulse  <= stb.wr && stb.revalHit && wrData[0];
      revalRegion <= stb.region;
    end
  end

  AST_PHYS_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (stb.wr && stb.regHit && !stb.shadow && stb.kind == KIND_DATA)
      |=> (bank[$past(stb.regIdx)] == $past(wrData))); // R2
  AST_UNOWNED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stb.rd && stb.regHit && stb.shadow) |=> ((rdData & ~$past(effMask)) == '0)); // R3
  AST_UNOWNED_BITS_HELD: assert property (@(posedge clk) disable iff (rst)
    (stb.wr && stb.regHit && stb.shadow)
      |=> (((bank[$past(stb.regIdx)] ^ $past(oldVal)) & ~$past(effMask)) == '0)); // R4
  AST_REVAL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    revalPulse |-> $past(stb.wr && stb.revalHit && wrData[0])); // R7
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stb.rd && !stb.regHit && !stb.maskHit) |=> (rdData == '0)); // R8
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !stb.rd |=> (rdData == '0)); // R9
endmodule

// File: rtl/dma_shadow_filter.sv
module dma_shadow_filter
  import shadow_filter_pkg::*;
#(
  parameter int AddrW = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AddrW-1:0]   addr,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [DataW-1:0]   wrData,
  output logic [DataW-1:0]   rdData,
  output logic               revalPulse,
  output logic [RegionW-1:0] revalRegion
);
  strobe_t stb;

  shadow_filter_ctrl #(.AddrW(AddrW)) i_ctrl (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .stb  (stb)
  );

  shadow_filter_dp i_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .wrData      (wrData),
    .rdData      (rdData),
    .revalPulse  (revalPulse),
    .revalRegion (revalRegion)
  );
endmodule

// File: tb/test_dma_shadow_filter.sv
`timescale 1ns/1ps
module test_dma_shadow_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] addr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        revalPulse;
  logic [2:0]  revalRegion;

  int nVec = 0, nFail = 0;
  logic       expPulse = 1'b0;
  logic [2:0] expRgn = '0;

  typedef struct { logic [31:0] exp; string tag; int a; } item_t;
  item_t sbq[$];

  logic [31:0] mBank[15];
  logic [31:0] mLo[8], mHi[8], mQ[8];

  localparam int BaseTab[14] = '{0,0,0,1,2,2,2,3,3,4,4,4,5,5};
  localparam int KindTab[14] = '{0,1,2,0,0,1,2,0,2,0,1,2,0,2};
  localparam int DataJ[6]    = '{0,3,4,7,9,12};

  always #2 clk = ~clk;

  dma_shadow_filter i_dma_shadow_filter (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .revalPulse(revalPulse), .revalRegion(revalRegion)
  );

  function automatic void mapRef(input int w, output bit hit, output int idx, output int kind);
    hit = 1; idx = 0; kind = 0;
    if (w < 28) begin idx = BaseTab[w/2]*2 + w%2; kind = KindTab[w/2]; end
    else case (w)
      28: idx = 12;
      29: idx = 13;
      30: begin idx = 13; kind = 1; end
      31: begin idx = 13; kind = 2; end
      32: idx = 14;
      33: begin idx = 14; kind = 2; end
      default: hit = 0;
    endcase
  endfunction

  // cls: 0 unmapped, 1 physical reg, 2 shadow reg, 3 mask reg, 4 reval
  function automatic void decodeAddr(input int a, output int cls, output int idx,
                                     output int kind, output int rgn, output int msel);
    int w; bit inWin, shadow, hit;
    w = (a >> 2) & 63; inWin = (w <= 37);
    cls = 0; idx = 0; kind = 0; rgn = 0; msel = 0; shadow = 0;
    if ((a >> 8) == 16 && inWin) cls = 1;
    else if ((a >> 12) == 2 && ((a >> 8) & 1) == 0 && inWin) begin
      cls = 2; shadow = 1; rgn = (a >> 9) & 7;
    end
    else if ((a >> 6) == 13) begin cls = 3; rgn = (a >> 3) & 7; msel = (a >> 2) & 1; return; end
    else if ((a >> 5) == 28) begin cls = 3; rgn = (a >> 2) & 7; msel = 2; return; end
    else return;
    if (w == 37) begin cls = shadow ? 4 : 0; return; end
    mapRef(w, hit, idx, kind);
    if (!hit) cls = 0;
  endfunction

  function automatic logic [31:0] maskOf(input int cls, input int idx, input int rgn);
    if (cls != 2) return '1;
    if (idx >= 12) return mQ[rgn];
    if (idx % 2 == 1) return mHi[rgn];
    return mLo[rgn];
  endfunction

  function automatic int dataWordOf(input int idx);
    if (idx < 12) return 2*DataJ[idx/2] + idx%2;
    if (idx == 12) return 28;
    if (idx == 13) return 29;
    return 32;
  endfunction

  function automatic int shAddr(input int r, input int w);
    return 32'h2000 + r*32'h200 + w*4;
  endfunction

  task automatic busWr(input int a, input logic [31:0] d);
    int cls, idx, kind, rgn, msel;
    logic [31:0] m;
    decodeAddr(a, cls, idx, kind, rgn, msel);
    @(negedge clk);
    addr = 14'(a); wrData = d; wrEn = 1'b1;
    if (cls == 1 || cls == 2) begin
      m = maskOf(cls, idx, rgn);
      case (kind)
        1: mBank[idx] = mBank[idx] | (d & m);
        2: mBank[idx] = mBank[idx] & ~(d & m);
        default: mBank[idx] = (mBank[idx] & ~m) | (d & m);
      endcase
    end else if (cls == 3) begin
      if (msel == 0) mLo[rgn] = d; else if (msel == 1) mHi[rgn] = d; else mQ[rgn] = d;
    end else if (cls == 4) begin
      expPulse = d[0]; expRgn = 3'(rgn);
    end
    @(negedge clk);
    wrEn = 1'b0; expPulse = 1'b0;
  endtask

  task automatic busRd(input int a, input string tag);
    int cls, idx, kind, rgn, msel;
    item_t it;
    decodeAddr(a, cls, idx, kind, rgn, msel);
    it.exp = '0; it.tag = tag; it.a = a;
    if ((cls == 1 || cls == 2) && kind == 0) it.exp = mBank[idx] & maskOf(cls, idx, rgn);
    else if (cls == 3) it.exp = (msel == 0) ? mLo[rgn] : (msel == 1) ? mHi[rgn] : mQ[rgn];
    @(negedge clk);
    sbq.push_back(it);
    addr = 14'(a); rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readAllPhys(input string tag);
    for (int i = 0; i < 15; i++) busRd(32'h1000 + dataWordOf(i)*4, tag);
  endtask

  // Monitor: pops the scoreboard one cycle after a sampled read
  always @(posedge clk) begin
    automatic logic       took = rdEn;
    automatic logic       ep   = expPulse;
    automatic logic [2:0] er   = expRgn;
    item_t it;
    #1;
    if (!rst) begin
      nVec++;
      if (took) begin
        if (sbq.size() == 0) begin
          nFail++; $display("FAIL R9 read data with empty scoreboard actual=%h expected=none", rdData);
        end else begin
          it = sbq.pop_front();
          if (rdData !== it.exp) begin
            nFail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdData, it.exp);
          end
        end
      end else if (rdData !== 32'h0) begin
        nFail++; $display("FAIL R9 idle rdData actual=%h expected=00000000", rdData);
      end
      nVec++;
      if (revalPulse !== ep || (ep && revalRegion !== er)) begin
        nFail++;
        $display("FAIL R7 pulse actual=%b/%0d expected=%b/%0d", revalPulse, revalRegion, ep, er);
      end
    end
  end

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) mBank[i] = '0;
    for (int r = 0; r < 8; r++) begin mLo[r] = '0; mHi[r] = '0; mQ[r] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of bank and masks
    readAllPhys("R1");
    busRd(32'h340, "R1"); busRd(32'h37C, "R1"); busRd(32'h39C, "R1");

    // R2: full-word physical writes and readback
    for (int i = 0; i < 15; i++) busWr(32'h1000 + dataWordOf(i)*4, 32'h9E3779B9 * (i + 1));
    readAllPhys("R2");

    // R6: program and read back ownership masks
    busWr(32'h340 + 8*2, 32'h0000FFFF);
    busWr(32'h344 + 8*2, 32'hF0F0F0F0);
    busWr(32'h380 + 4*2, 32'h000000AA);
    busWr(32'h340 + 8*6, 32'hFFFFFFFF);
    busRd(32'h340 + 8*2, "R6"); busRd(32'h344 + 8*2, "R6");
    busRd(32'h380 + 4*2, "R6"); busRd(32'h340 + 8*6, "R6"); busRd(32'h344 + 8*6, "R6");

    // R3: masked shadow reads in a mixed, an empty and a low-only region
    for (int i = 0; i < 15; i++) busRd(shAddr(2, dataWordOf(i)), "R3");
    for (int i = 0; i < 15; i++) busRd(shAddr(5, dataWordOf(i)), "R3");
    for (int i = 0; i < 15; i++) busRd(shAddr(6, dataWordOf(i)), "R3");

    // R4: shadow data writes keep unowned bits
    for (int i = 0; i < 15; i++) busWr(shAddr(2, dataWordOf(i)), 32'h0F1E2D3C ^ (32'h11111111 * i));
    busWr(shAddr(5, dataWordOf(3)), 32'hFFFFFFFF);
    readAllPhys("R4");

    // R5: set/clear aliases through a region and through the physical window
    busWr(shAddr(2, 10), 32'hFFFFFFFF);  // enable low set
    busWr(shAddr(2, 27), 32'hFFFFFFFF);  // pending high clear
    busWr(shAddr(2, 30), 32'hFFFFFFFF);  // QDMA enable set
    busWr(shAddr(2, 33), 32'hFFFFFFFF);  // QDMA secondary clear
    busWr(shAddr(5, 11), 32'hFFFFFFFF);  // empty region enable high set
    busWr(32'h1000 + 4*4, 32'hFFFF0000); // physical event low clear
    busWr(32'h1000 + 3*4, 32'h00000005); // physical event high set
    busRd(shAddr(2, 10), "R5"); busRd(32'h1000 + 30*4, "R5");
    readAllPhys("R5");

    // R7: re-evaluate pulses ignore masks; bit 0 clear gives none
    busWr(shAddr(3, 37), 32'h00000001);
    busWr(shAddr(7, 37), 32'hFFFFFFFF);
    busWr(shAddr(0, 37), 32'h00000002);
    busRd(shAddr(3, 37), "R7");

    // R8: unmapped writes have no effect and read 0
    busWr(32'h1088, '1); busWr(32'h108C, '1); busWr(32'h1090, '1);
    busWr(32'h1098, '1); busWr(32'h1094, '1); busWr(32'h2100, '1);
    busWr(32'h3000, '1); busWr(32'h0000, '1); busWr(32'h0300, '1);
    busRd(32'h1088, "R8"); busRd(32'h1094, "R8"); busRd(32'h2100, "R8"); busRd(32'h3000, "R8");
    readAllPhys("R8");
    busRd(32'h340 + 8*2, "R8"); busRd(32'h380 + 4*0, "R8");

    // R9: back-to-back idle cycles after the last read
    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      nFail++; $display("FAIL R9 scoreboard left actual=%0d expected=0", sbq.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule